// File: doc/BRIEF.md
# Single-Tape Turing Machine Engine

This block is a small hardware Turing machine. A 16-cell binary tape is held in a register. A head pointer selects one cell. A five-state controller executes a fixed program that copies a unary value. On each enabled clock the engine reads the cell under the head and looks the pair (state, bit) up in a built-in action table. It then writes a bit back, moves the head one cell and takes the next state.

A `start` pulse loads the initial tape, homes the head and arms the engine. Each clock in which `step_en` is high while the engine is armed executes exactly one step. The run ends in one of two ways:

- The engine reaches the halt pair (state 1 reading 0) and raises `done`.
- A move would leave the tape, and the engine raises `fault`.

The state, the head position and every tape cell are visible on the ports, so a harness can follow the trace step by step.

Top module: `tape_engine`

## Requirements
- R1: After reset the engine holds state code 1, head position SEG_OFS, `done` = 0 and `fault` = 0, and is not armed. Tape bit i on `tape_o[i]` is 1 only for i = SEG_OFS and i = SEG_OFS+1; every other cell is 0. Cells past the tape end are dropped.
- R2: A `start` pulse restores the R1 tape, head and state, clears `done` and `fault`, and arms the engine. This holds when the engine is idle, running, halted or faulted. When `start` and `step_en` are high in the same cycle, `start` wins and no step is taken.
- R3: While armed, exactly one step is taken per clock with `step_en` high. A cycle with `step_en` low changes nothing.
- R4: The state is a 3-bit code from 1 to 5. A right move increments the head; a left move decrements it. The action table is:

  | State | Bit read | Bit written | Move | Next state |
  |---|---|---|---|---|
  | 1 | 1 | 0 | right | 2 |
  | 2 | 1 | 1 | right | 2 |
  | 2 | 0 | 0 | right | 3 |
  | 3 | 1 | 1 | right | 3 |
  | 3 | 0 | 1 | left | 4 |
  | 4 | 1 | 1 | left | 4 |
  | 4 | 0 | 0 | left | 5 |
  | 5 | 1 | 1 | left | 5 |
  | 5 | 0 | 1 | right | 1 |
- R5: A step taken in state 1 reading 0 is the halt. It writes nothing, moves nothing, keeps state 1, sets `done` and disarms the engine. `done` stays high until the next `start`.
- R6: `step_en` has no effect when the engine is not armed: before the first `start`, after halt and after a fault.
- R7: A step that would move the head right from cell TAPE_W-1, or left from cell 0, writes nothing and moves nothing. It keeps the state, sets `fault` and disarms the engine. `fault` stays high until `start`.
- R8: From `start`, `done` is still low after 14 steps and rises after the 15th. The engine is then in state 1 with the head at SEG_OFS+2. Cells SEG_OFS..SEG_OFS+4 hold 1,1,0,1,1, and all other cells are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the initial tape and arm the engine |
| step_en | input | 1 | Execute one step this clock if armed |
| done | output | 1 | Halt reached; held until start |
| fault | output | 1 | Head tried to leave the tape; held until start |
| state_o | output | 3 | Current control state code (1 to 5) |
| head_o | output | $clog2(TAPE_W) | Head position |
| tape_o | output | TAPE_W | All tape cells, bit i is cell i |

## Verification
Two collisions are provoked on purpose.

The first is a `start` in the same cycle as `step_en`, sent once while the engine is idle and once in the middle of a run. It is judged by the state, head and tape showing the freshly loaded values with no step applied.

The second is the step that would both write and move being overruled by an end-of-tape check. A second instance places the segment at offset 12, so its tenth step tries to move right from cell 15. That instance must show `fault` with the tape and head exactly as they stood after step nine.

// File: rtl/tape_pkg.sv
package tape_pkg;

    typedef enum logic [2:0] {
        Q1 = 3'd1,
        Q2 = 3'd2,
        Q3 = 3'd3,
        Q4 = 3'd4,
        Q5 = 3'd5
    } ctl_e;

    typedef struct packed {
        logic halt;
        logic wbit;
        logic go_right;
        ctl_e nxt;
    } act_t;

    function automatic act_t step_lookup(ctl_e s, logic b);
        act_t a;
        a.halt     = 1'b0;
        a.wbit     = b;
        a.go_right = 1'b1;
        a.nxt      = s;
        case (s)
            Q1: begin
                if (b) begin
                    a.wbit = 1'b0; a.go_right = 1'b1; a.nxt = Q2;
                end else begin
                    a.halt = 1'b1;
                end
            end
            Q2: begin
                if (b) begin
                    a.wbit = 1'b1; a.go_right = 1'b1; a.nxt = Q2;
                end else begin
                    a.wbit = 1'b0; a.go_right = 1'b1; a.nxt = Q3;
                end
            end
            Q3: begin
                if (b) begin
                    a.wbit = 1'b1; a.go_right = 1'b1; a.nxt = Q3;
                end else begin
                    a.wbit = 1'b1; a.go_right = 1'b0; a.nxt = Q4;
                end
            end
            Q4: begin
                if (b) begin
                    a.wbit = 1'b1; a.go_right = 1'b0; a.nxt = Q4;
                end else begin
                    a.wbit = 1'b0; a.go_right = 1'b0; a.nxt = Q5;
                end
            end
            Q5: begin
                if (b) begin
                    a.wbit = 1'b1; a.go_right = 1'b0; a.nxt = Q5;
                end else begin
                    a.wbit = 1'b1; a.go_right = 1'b1; a.nxt = Q1;
                end
            end
            default: begin
                a.halt = 1'b1;
            end
        endcase
        return a;
    endfunction

endpackage

// File: rtl/head_ptr.sv
module head_ptr #(
    parameter int W    = 16,
    parameter int HOME = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 move,
    input  logic                 go_right,
    output logic [$clog2(W)-1:0] pos,
    output logic                 at_edge
);
    localparam int HW = $clog2(W);
    localparam logic [HW-1:0] LAST  = HW'(W - 1);
    localparam logic [HW-1:0] START = HW'(HOME);

    assign at_edge = go_right ? (pos == LAST) : (pos == '0);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            pos <= START;
        end else if (move) begin
            pos <= go_right ? pos + 1'b1 : pos - 1'b1;
        end
    end

    // R4: a move steps the head by exactly one cell in the chosen direction
    assert_right_step_R4: assert property (@(posedge clk) disable iff (rst)
        (move && go_right && !load) |=> (pos == $past(pos) + 1'b1));
    assert_left_step_R4: assert property (@(posedge clk) disable iff (rst)
        (move && !go_right && !load) |=> (pos == $past(pos) - 1'b1));
    // R7: the head is never moved off the tape
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        !(move && at_edge));
endmodule

// File: rtl/tape_store.sv
module tape_store #(
    parameter int W   = 16,
    parameter int OFS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 wr,
    input  logic [$clog2(W)-1:0] addr,
    input  logic                 wbit,
    output logic [W-1:0]         cells,
    output logic                 rd_bit
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] init_pat;

    for (genvar i = 0; i < W; i++) begin : g_init
        assign init_pat[i] = (i == OFS) || (i == OFS + 1);
    end

    assign rd_bit = cells[addr];

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cells <= init_pat;
        end else if (wr) begin
            cells[addr] <= wbit;
        end
    end

    // R3: outside a load, no cell other than the addressed one may change
    assert_single_cell_R3: assert property (@(posedge clk) disable iff (rst)
        !load |=> (((cells ^ $past(cells)) & ~(ONE << $past(addr))) == '0));
    // R3: with no write and no load the tape is frozen
    assert_tape_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !wr) |=> $stable(cells));
endmodule

// File: rtl/tape_engine.sv
module tape_engine
    import tape_pkg::*;
#(
    parameter int TAPE_W  = 16,
    parameter int SEG_OFS = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      step_en,
    output logic                      done,
    output logic                      fault,
    output logic [2:0]                state_o,
    output logic [$clog2(TAPE_W)-1:0] head_o,
    output logic [TAPE_W-1:0]         tape_o
);
    localparam int HW = $clog2(TAPE_W);

    ctl_e              state_q;
    logic              running_q;
    logic              done_q;
    logic              fault_q;
    logic              rd_bit;
    logic              at_edge;
    logic              fire;
    logic              do_move;
    logic [HW-1:0]     head_q;
    logic [TAPE_W-1:0] tape_q;
    act_t              act;

    assign act     = step_lookup(state_q, rd_bit);
    assign fire    = running_q && step_en && !start;
    assign do_move = fire && !act.halt && !at_edge;

    head_ptr #(.W(TAPE_W), .HOME(SEG_OFS)) u_head (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .move     (do_move),
        .go_right (act.go_right),
        .pos      (head_q),
        .at_edge  (at_edge)
    );

    tape_store #(.W(TAPE_W), .OFS(SEG_OFS)) u_tape (
        .clk    (clk),
        .rst    (rst),
        .load   (start),
        .wr     (do_move),
        .addr   (head_q),
        .wbit   (act.wbit),
        .cells  (tape_q),
        .rd_bit (rd_bit)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            state_q   <= Q1;
            running_q <= !rst;
            done_q    <= 1'b0;
            fault_q   <= 1'b0;
        end else if (fire) begin
            if (act.halt) begin
                done_q    <= 1'b1;
                running_q <= 1'b0;
            end else if (at_edge) begin
                fault_q   <= 1'b1;
                running_q <= 1'b0;
            end else begin
                state_q <= act.nxt;
            end
        end
    end

    assign done    = done_q;
    assign fault   = fault_q;
    assign state_o = state_q;
    assign head_o  = head_q;
    assign tape_o  = tape_q;

    always_comb begin
        if (!rst) begin
            assert_state_legal_R4: assert (state_q inside {Q1, Q2, Q3, Q4, Q5});
        end
    end

    // R5: done is held until start
    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    // R5: halting only happens in state 1
    assert_done_in_q1_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (state_o == 3'd1));
    // R7: fault is held until start and never coexists with done
    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (fault && !start) |=> fault);
    assert_end_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));
    // R6: after halt or fault, stepping changes nothing
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ((done || fault) && !start) |=> ($stable(state_o) && $stable(head_o) && $stable(tape_o)));
    // R2: start reloads the head home
    assert_start_home_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (head_o == HW'(SEG_OFS) && state_o == 3'd1 && !done && !fault));
endmodule

// File: tb/tape_engine_test.sv
module tape_engine_test;
    localparam int W  = 16;
    localparam int OA = 2;
    localparam int OB = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic step_en = 1'b0;

    logic done0, fault0, done1, fault1;
    logic [2:0] st0, st1;
    logic [3:0] hd0, hd1;
    logic [W-1:0] tp0, tp1;

    always #10 clk = ~clk;

    tape_engine #(.TAPE_W(W), .SEG_OFS(OA)) uut (
        .clk(clk), .rst(rst), .start(start), .step_en(step_en),
        .done(done0), .fault(fault0), .state_o(st0), .head_o(hd0), .tape_o(tp0));

    tape_engine #(.TAPE_W(W), .SEG_OFS(OB)) uut_edge (
        .clk(clk), .rst(rst), .start(start), .step_en(step_en),
        .done(done1), .fault(fault1), .state_o(st1), .head_o(hd1), .tape_o(tp1));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;

    typedef struct {
        int       due;
        int       u;
        int       st;
        int       hd;
        logic [W-1:0] tp;
        bit       dn;
        bit       er;
        string    tag;
    } exp_t;

    exp_t q[$];

    int       m_st [2];
    int       m_hd [2];
    logic [W-1:0] m_tp [2];
    bit       m_dn [2];
    bit       m_er [2];
    bit       m_run[2];
    int       m_ofs[2] = '{OA, OB};

    function automatic void m_init(int u);
        m_tp[u] = '0;
        for (int i = 0; i < W; i++) begin
            if (i == m_ofs[u] || i == m_ofs[u] + 1) m_tp[u][i] = 1'b1;
        end
        m_st[u] = 1;
        m_hd[u] = m_ofs[u];
        m_dn[u] = 1'b0;
        m_er[u] = 1'b0;
    endfunction

    function automatic void m_step(int u);
        bit b, h, wv, rgt;
        int nx;
        b = m_tp[u][m_hd[u]];
        h = 1'b0; wv = 1'b0; rgt = 1'b1; nx = m_st[u];
        if (m_st[u] == 1 && !b) h = 1'b1;
        else if (m_st[u] == 1) begin wv = 0; rgt = 1; nx = 2; end
        else if (m_st[u] == 2) begin wv = b; rgt = 1; nx = b ? 2 : 3; end
        else if (m_st[u] == 3) begin wv = 1; rgt = b; nx = b ? 3 : 4; end
        else if (m_st[u] == 4) begin wv = b; rgt = 0; nx = b ? 4 : 5; end
        else begin wv = 1; rgt = !b; nx = b ? 5 : 1; end
        if (h) begin
            m_dn[u] = 1'b1; m_run[u] = 1'b0;
        end else if ((rgt && m_hd[u] == W - 1) || (!rgt && m_hd[u] == 0)) begin
            m_er[u] = 1'b1; m_run[u] = 1'b0;
        end else begin
            m_tp[u][m_hd[u]] = wv;
            m_hd[u] = rgt ? m_hd[u] + 1 : m_hd[u] - 1;
            m_st[u] = nx;
        end
    endfunction

    function automatic void push(int u, string tag);
        exp_t e;
        e.due = cyc + 1; e.u = u; e.st = m_st[u]; e.hd = m_hd[u];
        e.tp = m_tp[u]; e.dn = m_dn[u]; e.er = m_er[u]; e.tag = tag;
        q.push_back(e);
    endfunction

    task automatic drive(bit s, bit e, string tag);
        @(negedge clk);
        start = s;
        step_en = e;
        for (int u = 0; u < 2; u++) begin
            if (s) begin
                m_init(u);
                m_run[u] = 1'b1;
            end else if (m_run[u] && e) begin
                m_step(u);
            end
            push(u, tag);
        end
    endtask

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            int a_st, a_hd;
            logic [W-1:0] a_tp;
            bit a_dn, a_er;
            e = q.pop_front();
            a_st = (e.u == 0) ? int'(st0) : int'(st1);
            a_hd = (e.u == 0) ? int'(hd0) : int'(hd1);
            a_tp = (e.u == 0) ? tp0 : tp1;
            a_dn = (e.u == 0) ? done0 : done1;
            a_er = (e.u == 0) ? fault0 : fault1;
            total++;
            if (a_st != e.st || a_hd != e.hd || a_tp != e.tp || a_dn != e.dn || a_er != e.er) begin
                bad++;
                $display("FAIL %s inst%0d actual st=%0d hd=%0d tp=%h dn=%0b er=%0b expected st=%0d hd=%0d tp=%h dn=%0b er=%0b",
                         e.tag, e.u, a_st, a_hd, a_tp, a_dn, a_er, e.st, e.hd, e.tp, e.dn, e.er);
            end
        end
    end

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        m_init(0); m_init(1);
        m_run[0] = 1'b0; m_run[1] = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        push(0, "R1"); push(1, "R1");

        // R6: stepping before any start is ignored
        drive(0, 1, "R6");
        drive(0, 1, "R6");
        // R2: start and step together, start wins
        drive(1, 1, "R2");

        // R3/R4: run the program with idle gaps
        n = 0;
        while (n < 15) begin
            drive(0, 1, "R4");
            n++;
            if (n == 15) begin
                chk(done0 == 1'b0, "R8", "done after 14 steps", int'(done0), 0);
            end
            if (n % 3 == 0) drive(0, 0, "R3");
        end

        // R8: final trace result
        chk(done0 == 1'b1, "R8", "done", int'(done0), 1);
        chk(st0 == 3'd1, "R8", "state", int'(st0), 1);
        chk(hd0 == 4'(OA + 2), "R8", "head", int'(hd0), OA + 2);
        chk(tp0 == (16'b11011 << OA), "R8", "tape", int'(tp0), int'(16'b11011 << OA));
        // R7: edge instance faulted on its tenth step, nothing applied
        chk(fault1 == 1'b1 && done1 == 1'b0, "R7", "fault", int'(fault1), 1);
        chk(hd1 == 4'd15, "R7", "head", int'(hd1), 15);
        chk(st1 == 3'd3, "R7", "state", int'(st1), 3);
        chk(tp1 == 16'b1001_0000_0000_0000, "R7", "tape", int'(tp1), 16'h9000);

        // R5/R6: steps after halt and fault change nothing
        drive(0, 1, "R5");
        drive(0, 1, "R6");
        drive(0, 1, "R5");
        drive(0, 0, "R5");
        chk(done0 == 1'b1, "R5", "done held", int'(done0), 1);
        chk(fault1 == 1'b1, "R7", "fault held", int'(fault1), 1);

        // R2: restart, run partway, restart mid-run with a step request
        drive(1, 0, "R2");
        for (int k = 0; k < 5; k++) drive(0, 1, "R4");
        drive(1, 1, "R2");
        drive(0, 0, "R2");
        chk(st0 == 3'd1 && hd0 == 4'(OA) && done0 == 1'b0, "R2", "reload head", int'(hd0), OA);
        drive(0, 1, "R3");
        drive(0, 0, "R3");
        repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule